// File: doc/BRIEF.md
# Outage Duration Counter with Serial Readout

This block measures how long the main supply was missing and hands the figure to a host over two wires. While the cut-off input is high, rising edges of a slow reference oscillator are divided by 1024 into a tick of about one second. Each tick advances a 15-bit outage counter. When the cut-off condition ends, the count is copied into a shift register. The host then reads it most significant bit first by pulsing a shift clock.

Once all fifteen bits have been clocked out, the data pin carries the raw reference oscillator. The host can measure its period and convert the tick count into real time. While the supply is present, the divided tick also appears on its own calibration output.

Every pin is a plain level signal. There is no stream traffic and so no valid/ready handshake. The host paces the readout entirely through its shift clock, and nothing in the block can push back on it.

The host shift clock passes through a two-stage synchronizer into the system clock domain. That domain must run at least four times faster than the shift clock. While cut-off is high, the host clock is forced to zero before it reaches the synchronizer.

Top module: `outage_timer`

## Requirements
- R1: The prescaler produces one tick for every 1024 rising edges of `osc_in`. It is cleared in the cycle that cut-off begins, so an outage shorter than 1024 oscillator periods yields a count of 0.
- R2: The outage counter is cleared when cut-off begins. It then increases by one on every tick while cut-off is high, so an outage of N×1024+512 oscillator periods reads back as N.
- R3: The outage counter saturates at all ones (0x7FFF at the default width) instead of wrapping.
- R4: After reset, and one cycle after cut-off falls, the shift register holds the counter value, the bit counter is 0, and `q_out` shows the most significant bit before any host clock edge.
- R5: Each rising edge of `host_sclk` moves the next lower count bit onto `q_out`, so the 15 bits appear most significant bit first.
- R6: After the fifteenth host clock edge, `q_out` follows `osc_in` directly. Further host clock edges have no effect until the next load.
- R7: While cut-off is low, `tick_out` is a square wave with a period of 1024 oscillator periods. While cut-off is high, `tick_out` is 0.
- R8: While cut-off is high, host clock edges do not move the shift register, and `q_out` keeps its value.
- R9: With a 50 MHz system clock, every edge of a 10 MHz host clock is captured, so 14 fast edges leave bit 0 on `q_out` and 15 leave the oscillator there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the host shift clock |
| rst_n | input | 1 | Active-low power-on reset |
| cut_off | input | 1 | High while the main supply is absent, synchronous to clk |
| osc_in | input | 1 | Slow reference oscillator (nominal 1024 Hz) |
| host_sclk | input | 1 | Host shift clock, asynchronous, up to 10 MHz |
| q_out | output | 1 | Serial count bit (MSB first), then the raw oscillator |
| tick_out | output | 1 | Oscillator divided by 1024, forced low during an outage |

## Verification
The bench drives outages of known tick length, each with a half-tick margin, and reads the counts back bit by bit. A prescaler that was not cleared at outage start, or a counter that missed its clear, would show up as a count one above the expected value. It starts a second outage after a partial readout and pulses the host clock during that outage. An ungated host clock would change the pending bit or switch the pin to the oscillator early.

The bench also clocks 14 and then 15 edges at 10 MHz. A synchronizer that drops edges would leave a stale bit or never hand the pin over to the oscillator. A bit counter that does not hold at 15 would resume shifting out zeros on later host clocks. A small-width instance runs past full scale, so a counter that wraps would read back a low count.

// File: rtl/outage_pkg.sv
package outage_pkg;
  localparam int unsigned COUNT_BITS_DEF = 15;
  localparam int unsigned DIV_BITS_DEF   = 10;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef enum logic {
    SRC_SHIFT = 1'b0,
    SRC_OSC   = 1'b1
  } qsrc_e;
endpackage

// File: rtl/outage_sync_edge.sv
module outage_sync_edge #(
  parameter int unsigned STAGES = outage_pkg::SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], din};
  end

  // Edge is taken between the last synchronizing stage and one extra flop.
  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/outage_prescaler.sv
module outage_prescaler #(
  parameter int unsigned DIV_W = outage_pkg::DIV_BITS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic osc_rise,
  output logic tick,
  output logic phase_msb
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (clear)    div_q <= '0;
    else if (osc_rise) div_q <= div_q + 1'b1;
  end

  assign tick      = osc_rise & ~clear & (&div_q);
  assign phase_msb = div_q[DIV_W-1];
endmodule

// File: rtl/outage_counter.sv
module outage_counter #(
  parameter int unsigned CNT_W = outage_pkg::COUNT_BITS_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count <= '0;
    else if (clear)                      count <= '0;
    else if (enable && tick && !(&count)) count <= count + 1'b1;
  end
endmodule

// File: rtl/outage_readout.sv
module outage_readout #(
  parameter int unsigned CNT_W = outage_pkg::COUNT_BITS_DEF,
  localparam int unsigned BC_W = $clog2(CNT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             shift,
  input  logic             osc_in,
  output logic             q_out,
  output logic [CNT_W-1:0] shreg,
  output logic [BC_W-1:0]  bit_cnt
);
  import outage_pkg::*;

  localparam logic [BC_W-1:0] LAST = BC_W'(CNT_W);

  qsrc_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      shreg   <= load_val;
      bit_cnt <= '0;
    end else if (shift && bit_cnt != LAST) begin
      shreg   <= {shreg[CNT_W-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign src   = (bit_cnt == LAST) ? SRC_OSC : SRC_SHIFT;
  assign q_out = (src == SRC_OSC) ? osc_in : shreg[CNT_W-1];
endmodule

// File: rtl/outage_timer.sv
module outage_timer #(
  parameter int unsigned CNT_W       = outage_pkg::COUNT_BITS_DEF,
  parameter int unsigned DIV_W       = outage_pkg::DIV_BITS_DEF,
  parameter int unsigned SYNC_STAGES = outage_pkg::SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cut_off,
  input  logic osc_in,
  input  logic host_sclk,
  output logic q_out,
  output logic tick_out
);
  localparam int unsigned BC_W = $clog2(CNT_W + 1);

  logic             cut_q;
  logic             start, stop;
  logic             host_gated;
  logic             osc_rise, host_rise;
  logic             tick, phase_msb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] shreg;
  logic [BC_W-1:0]  bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cut_q <= 1'b0;
    else        cut_q <= cut_off;
  end

  assign start      = cut_off & ~cut_q;
  assign stop       = ~cut_off & cut_q;
  assign host_gated = host_sclk & ~cut_off;

  outage_sync_edge #(.STAGES(SYNC_STAGES)) u_osc_sync (
    .clk(clk), .rst_n(rst_n), .din(osc_in), .rise(osc_rise)
  );

  outage_sync_edge #(.STAGES(SYNC_STAGES)) u_host_sync (
    .clk(clk), .rst_n(rst_n), .din(host_gated), .rise(host_rise)
  );

  outage_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(start), .osc_rise(osc_rise),
    .tick(tick), .phase_msb(phase_msb)
  );

  outage_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clear(start), .enable(cut_off),
    .tick(tick), .count(count)
  );

  outage_readout #(.CNT_W(CNT_W)) u_read (
    .clk(clk), .rst_n(rst_n), .load(stop), .load_val(count),
    .shift(host_rise), .osc_in(osc_in), .q_out(q_out),
    .shreg(shreg), .bit_cnt(bit_cnt)
  );

  assign tick_out = phase_msb & ~cut_off;
endmodule

// File: rtl/outage_timer_checker.sv
module outage_timer_checker #(
  parameter int unsigned CNT_W = 15,
  localparam int unsigned BC_W = $clog2(CNT_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cut_off,
  input logic             osc_in,
  input logic             q_out,
  input logic             tick_out,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] shreg,
  input logic [BC_W-1:0]  bit_cnt
);
  localparam logic [BC_W-1:0]  LAST = BC_W'(CNT_W);
  localparam logic [CNT_W-1:0] FULL = '1;

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cut_off) |=> count == '0);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_off && $past(cut_off) && tick && count != FULL) |=> count == $past(count) + 1'b1);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && !$rose(cut_off)) |=> count == FULL);

  assert_load_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cut_off) |=> (bit_cnt == '0 && q_out == $past(count[CNT_W-1])));

  assert_osc_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == LAST) |-> q_out == osc_in);

  assert_hold_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == LAST && !$fell(cut_off)) |=> bit_cnt == LAST);

  assert_quiet_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_out) |-> !cut_off);

  assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_off && $past(cut_off) && $past(cut_off, 2) && $past(cut_off, 3)) |-> $stable(shreg));
endmodule

bind outage_timer outage_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cut_off(cut_off), .osc_in(osc_in),
  .q_out(q_out), .tick_out(tick_out), .tick(tick), .count(count),
  .shreg(shreg), .bit_cnt(bit_cnt)
);

// File: tb/outage_timer_test.sv
`timescale 1ns/1ps
module outage_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc = 1'b0;
  logic cut = 1'b0, sclk = 1'b0;
  logic cut2 = 1'b0, sclk2 = 1'b0;
  logic q, tk, q2, tk2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always #40 osc = ~osc;   // 4 system cycles per oscillator period

  outage_timer uut (.clk(clk), .rst_n(rst_n), .cut_off(cut), .osc_in(osc),
                    .host_sclk(sclk), .q_out(q), .tick_out(tk));

  outage_timer #(.CNT_W(4), .DIV_W(2)) uut_sat (.clk(clk), .rst_n(rst_n),
                    .cut_off(cut2), .osc_in(osc), .host_sclk(sclk2),
                    .q_out(q2), .tick_out(tk2));

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_slow();
    sclk = 1'b1; cyc(4);
    sclk = 1'b0; cyc(4);
  endtask

  task automatic pulse_fast();
    sclk = 1'b1; #50;
    sclk = 1'b0; #50;
  endtask

  task automatic outage(input int ticks);
    cut = 1'b1;
    cyc(ticks * 4096 + 2048);
    cut = 1'b0;
    cyc(3);
  endtask

  // Read nbits MSB first starting at bit index top; the first bit needs no edge.
  task automatic read_bits(input int value, input int top, input int nbits, input string tag);
    for (int i = 0; i < nbits; i++) begin
      if (i > 0 || top != 14) pulse_slow();
      check(q == value[top - i], tag, int'(q), value[top - i]);
    end
  endtask

  task automatic check_osc_follow(input string tag);
    int seen_hi = 0, seen_lo = 0;
    for (int i = 0; i < 12; i++) begin
      check(q == osc, tag, int'(q), int'(osc));
      if (osc) seen_hi++; else seen_lo++;
      cyc(1);
    end
    check(seen_hi > 0 && seen_lo > 0, {tag, " both levels"}, seen_hi, seen_lo);
  endtask

  task automatic t_reset();
    check(q == 1'b0, "R4 reset q_out", int'(q), 0);
    check(tk == 1'b0, "R7 reset tick_out", int'(tk), 0);
    read_bits(0, 14, 15, "R4 reset count bits");
    pulse_slow();
    check_osc_follow("R6 after reset readout");
  endtask

  task automatic t_short_outage();
    cut = 1'b1; cyc(1000); cut = 1'b0; cyc(3);
    read_bits(0, 14, 15, "R1 short outage reads zero");
  endtask

  task automatic t_gating();
    outage(2);
    read_bits(2, 14, 14, "R5 count two bits");   // q now shows bit 1 (=1)
    cut = 1'b1;
    cyc(10);
    check(tk == 1'b0, "R7 tick_out low in outage", int'(tk), 0);
    for (int i = 0; i < 3; i++) begin
      pulse_slow();
      check(q == 1'b1, "R8 host edge during outage", int'(q), 1);
    end
    cyc(4096 + 2048 - 10 - 24);
    cut = 1'b0;
    cyc(3);
    read_bits(1, 14, 15, "R2 count one bits");
    pulse_slow();
    check_osc_follow("R6 after fifteen edges");
    for (int i = 0; i < 4; i++) pulse_slow();
    check_osc_follow("R6 extra edges ignored");
  endtask

  task automatic t_fast();
    outage(5);
    check(q == 1'b0, "R4 msb of five", int'(q), 0);
    for (int i = 0; i < 14; i++) pulse_fast();
    cyc(4);
    check(q == 1'b1, "R9 bit0 after 14 fast edges", int'(q), 1);
    pulse_fast();
    cyc(4);
    check_osc_follow("R9 osc after 15 fast edges");
  endtask

  task automatic t_tick_period();
    int n = 0;
    while (tk != 1'b0 && n < 10000) begin cyc(1); n++; end
    while (tk != 1'b1 && n < 10000) begin cyc(1); n++; end
    n = 0;
    while (tk != 1'b0 && n < 10000) begin cyc(1); n++; end
    while (tk != 1'b1 && n < 10000) begin cyc(1); n++; end
    check(n >= 4094 && n <= 4098, "R7 tick_out period cycles", n, 4096);
    check(n >= 4094 && n <= 4098, "R1 divide by 1024", n / 4, 1024);
  endtask

  task automatic t_saturate();
    int v = 0;
    cut2 = 1'b1; cyc(30 * 16 + 8); cut2 = 1'b0; cyc(3);
    for (int i = 0; i < 4; i++) begin
      if (i > 0) begin sclk2 = 1'b1; cyc(4); sclk2 = 1'b0; cyc(4); end
      v = (v << 1) | int'(q2);
    end
    check(v == 15, "R3 saturated count", v, 15);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_short_outage();
    t_gating();
    t_fast();
    t_tick_period();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #3_500_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule